// File: doc/BRIEF.md
# Time-Scheduled Signal Fault Injector

This block sits inline on a data word travelling from a producer to a consumer and corrupts it at a programmed moment. The moment is measured on a free-running tick count that the whole system shares, so the fault lands at the same point of the schedule on every run. Software arms one fault at a time with an effect code, a trigger tick, a lifetime and the effect's parameters. The lifetime is either a number of samples or permanent until reset. Boolean effects act on bit 0 of the word. Integer effects treat the whole word as signed two's complement.

The output is registered, so every sample, corrupted or clean, appears one clock after it is presented. With no fault in force the word passes through unchanged. Each clock is one time step for the drift and delay effects.

Top module: `tt_fault_injector`

## Requirements
- R1: After reset `dataOut` is 0. With no fault in force, `dataOut` equals the `dataIn` value sampled at the previous rising edge.
- R2: A pulse on `cfgArm` latches the whole configuration and arms the fault. The first corrupted sample is the one taken at the edge where `tick` equals the latched trigger tick. An armed fault fires once.
- R3: A transient fault (`cfgPermanent`=0) corrupts exactly `cfgDuration` consecutive samples, counting the trigger sample. A duration of 0 counts as 1. The sample after the last corrupted one passes through.
- R4: A permanent fault (`cfgPermanent`=1) corrupts every sample from its trigger until reset. `cfgArm` has no effect at an edge where a fault is in force.
- R5: Code 1 (invert) outputs the input with bit 0 complemented.
- R6: Code 2 (force bit) outputs the input with bit 0 replaced by bit 0 of `cfgValue`.
- R7: Code 3 (freeze) outputs the trigger sample and holds it while the fault lasts. Code 4 (conditional freeze) holds the previous output at every sample whose input equals `cfgValue`, and passes the input through otherwise.
- R8: Code 5 (constant) outputs `cfgValue`. Code 6 (offset) outputs input plus signed `cfgAmount`, clamped to the signed range of the word.
- R9: Code 7 (drift) outputs input plus k times signed `cfgAmount` on the k-th corrupted sample. Both the running sum and the result are clamped to the signed range. The sum restarts from zero on the next fault.
- R10: Code 8 (gain) outputs input times signed `cfgAmount`, clamped to the signed range.
- R11: Code 9 (delay) outputs the input from `cfgDelay` samples earlier, where any setting above 15 acts as 15. The history holds inputs taken since reset, and is 0 before any input has been taken.
- R12: The effect code is taken only at arming, so later changes of `cfgEffect` have no effect. Codes 0 and 10 to 15 pass the input through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | TICK_W | Shared free-running time base |
| cfgArm | input | 1 | One-cycle pulse that latches the configuration and arms the fault |
| cfgEffect | input | 4 | Effect code |
| cfgTrigTick | input | TICK_W | Tick value at which the fault starts |
| cfgDuration | input | DUR_W | Lifetime in samples for a transient fault |
| cfgPermanent | input | 1 | 1 selects a fault that lasts until reset |
| cfgValue | input | DATA_W | Forced bit, constant, or compare value |
| cfgAmount | input | DATA_W | Signed offset, drift step or gain |
| cfgDelay | input | DLY_W | Delay in samples, saturated to 15 |
| dataIn | input | DATA_W | Word from the producer |
| dataOut | output | DATA_W | Word to the consumer |

## Verification
Uniform random words show whether the passthrough path and the bit-0 effects leave the upper bits alone. Words near the signed extremes, together with large offsets, steps and gains, separate clamping from wrap-around in the offset, drift and gain effects. A pattern that often repeats the compare value tells conditional freeze apart from plain freeze and from passthrough. Noise on `cfgEffect` and stray `cfgArm` pulses while a fault is in force show whether the effect code is latched only at arming and whether re-arming is ignored. Directed runs with an oversized delay setting and with long permanent faults check the delay cap and the lifetime rules.

// File: rtl/tfi_pkg.sv
package tfi_pkg;

  typedef enum logic [3:0] {
    EFF_NONE      = 4'd0,
    EFF_INVERT    = 4'd1,
    EFF_FORCE     = 4'd2,
    EFF_FREEZE    = 4'd3,
    EFF_FREEZE_IF = 4'd4,
    EFF_CONST     = 4'd5,
    EFF_OFFSET    = 4'd6,
    EFF_DRIFT     = 4'd7,
    EFF_GAIN      = 4'd8,
    EFF_DELAY     = 4'd9
  } effect_e;

  // strobes from the scheduler to the datapath
  typedef struct packed {
    logic       load;      // configuration accepted this edge
    logic       effectOn;  // current sample is corrupted
    logic       first;     // current sample is the trigger sample
    logic [3:0] effect;    // latched effect code
  } ctrlStrobe_t;

endpackage

// File: rtl/tfi_ctrl.sv
module tfi_ctrl
  import tfi_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int DUR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TICK_W-1:0] tick,
  input  logic              cfgArm,
  input  logic [3:0]        cfgEffect,
  input  logic [TICK_W-1:0] cfgTrigTick,
  input  logic [DUR_W-1:0]  cfgDuration,
  input  logic              cfgPermanent,
  output ctrlStrobe_t       strobe
);

  logic              armedQ, activeQ, permQ;
  logic [DUR_W-1:0]  remQ, durQ;
  logic [TICK_W-1:0] trigQ;
  logic [3:0]        effQ;
  logic              start, effectOn, accept;

  assign start    = armedQ && (tick == trigQ);
  assign effectOn = start || activeQ;
  assign accept   = cfgArm && !effectOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ  <= 1'b0;
      activeQ <= 1'b0;
      permQ   <= 1'b0;
      remQ    <= '0;
      durQ    <= '0;
      trigQ   <= '0;
      effQ    <= '0;
    end else begin
      if (accept) begin
        armedQ <= 1'b1;
        trigQ  <= cfgTrigTick;
        durQ   <= cfgDuration;
        permQ  <= cfgPermanent;
        effQ   <= cfgEffect;
      end else if (start) begin
        armedQ <= 1'b0;
      end
      if (start) begin
        if (permQ) begin
          activeQ <= 1'b1;
        end else begin
          activeQ <= (durQ > DUR_W'(1));
          remQ    <= durQ - DUR_W'(1);
        end
      end else if (activeQ && !permQ) begin
        if (remQ == DUR_W'(1)) activeQ <= 1'b0;
        else                   remQ    <= remQ - DUR_W'(1);
      end
    end
  end

  always_comb begin
    strobe.load     = accept;
    strobe.effectOn = effectOn;
    strobe.first    = start;
    strobe.effect   = effQ;
  end

  AST_FIRES_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !armedQ); // R2
  AST_TRANSIENT_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && !permQ && !start && remQ == DUR_W'(1)) |=> !activeQ); // R3
  AST_PERMANENT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && permQ) |=> activeQ); // R4
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && permQ) |=> $stable(effQ)); // R4

endmodule

// File: rtl/tfi_datapath.sv
module tfi_datapath
  import tfi_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DLY_W  = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] cfgValue,
  input  logic [DATA_W-1:0] cfgAmount,
  input  logic [DLY_W-1:0]  cfgDelay,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int WIDE  = 2 * DATA_W + 2;
  localparam logic signed [WIDE-1:0] W_MAX = $signed((WIDE'(1) << (DATA_W - 1)) - WIDE'(1));
  localparam logic signed [WIDE-1:0] W_MIN = ~W_MAX;
  localparam logic [DLY_W-1:0] DLY_CAP = DLY_W'(DEPTH - 1);

  function automatic logic [DATA_W-1:0] clampS(input logic signed [WIDE-1:0] v);
    if (v > W_MAX) return W_MAX[DATA_W-1:0];
    if (v < W_MIN) return W_MIN[DATA_W-1:0];
    return v[DATA_W-1:0];
  endfunction

  function automatic logic signed [WIDE-1:0] widen(input logic [DATA_W-1:0] x);
    return WIDE'($signed(x));
  endfunction

  logic [DATA_W-1:0] valQ, amtQ, accQ, accNext, effOut, delayOut;
  logic [PTR_W-1:0]  dlyQ, wrPtr;
  logic [DATA_W-1:0] hist [DEPTH];
  logic signed [WIDE-1:0] inW, amtW;

  assign inW      = widen(dataIn);
  assign amtW     = widen(amtQ);
  assign accNext  = strobe.first ? amtQ : clampS(widen(accQ) + amtW);
  assign delayOut = (dlyQ == '0) ? dataIn : hist[wrPtr - dlyQ];

  always_comb begin
    case (strobe.effect)
      EFF_INVERT:    effOut = {dataIn[DATA_W-1:1], ~dataIn[0]};
      EFF_FORCE:     effOut = {dataIn[DATA_W-1:1], valQ[0]};
      EFF_FREEZE:    effOut = strobe.first ? dataIn : dataOut;
      EFF_FREEZE_IF: effOut = (dataIn == valQ) ? dataOut : dataIn;
      EFF_CONST:     effOut = valQ;
      EFF_OFFSET:    effOut = clampS(inW + amtW);
      EFF_DRIFT:     effOut = clampS(inW + widen(accNext));
      EFF_GAIN:      effOut = clampS(inW * amtW);
      EFF_DELAY:     effOut = delayOut;
      default:       effOut = dataIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      accQ    <= '0;
      valQ    <= '0;
      amtQ    <= '0;
      dlyQ    <= '0;
      wrPtr   <= '0;
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else begin
      dataOut     <= strobe.effectOn ? effOut : dataIn;
      accQ        <= (strobe.effectOn && strobe.effect == EFF_DRIFT) ? accNext : '0;
      hist[wrPtr] <= dataIn;
      wrPtr       <= wrPtr + PTR_W'(1);
      if (strobe.load) begin
        valQ <= cfgValue;
        amtQ <= cfgAmount;
        dlyQ <= (cfgDelay > DLY_CAP) ? PTR_W'(DEPTH - 1) : cfgDelay[PTR_W-1:0];
      end
    end
  end

  AST_PASSTHROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.effectOn |=> (dataOut == $past(dataIn))); // R1
  AST_INVERT_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.effectOn && strobe.effect == EFF_INVERT) |=> (dataOut[0] != $past(dataIn[0]))); // R5
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.effectOn && !strobe.first && strobe.effect == EFF_FREEZE) |=> $stable(dataOut)); // R7
  AST_CONST_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.effectOn && strobe.effect == EFF_CONST) |=> (dataOut == valQ)); // R8

endmodule

// File: rtl/tt_fault_injector.sv
module tt_fault_injector
  import tfi_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TICK_W = 32,
  parameter int DUR_W  = 16,
  parameter int DLY_W  = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TICK_W-1:0] tick,
  input  logic              cfgArm,
  input  logic [3:0]        cfgEffect,
  input  logic [TICK_W-1:0] cfgTrigTick,
  input  logic [DUR_W-1:0]  cfgDuration,
  input  logic              cfgPermanent,
  input  logic [DATA_W-1:0] cfgValue,
  input  logic [DATA_W-1:0] cfgAmount,
  input  logic [DLY_W-1:0]  cfgDelay,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);

  ctrlStrobe_t strobe;

  tfi_ctrl #(.TICK_W(TICK_W), .DUR_W(DUR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .cfgArm(cfgArm),
    .cfgEffect(cfgEffect), .cfgTrigTick(cfgTrigTick),
    .cfgDuration(cfgDuration), .cfgPermanent(cfgPermanent),
    .strobe(strobe)
  );

  tfi_datapath #(.DATA_W(DATA_W), .DLY_W(DLY_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgValue(cfgValue),
    .cfgAmount(cfgAmount), .cfgDelay(cfgDelay),
    .dataIn(dataIn), .dataOut(dataOut)
  );

endmodule

// File: tb/tb_tt_fault_injector.sv
module tb_tt_fault_injector;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] tick = '0;
  logic        cfgArm = 1'b0;
  logic [3:0]  cfgEffect = '0;
  logic [31:0] cfgTrigTick = '0;
  logic [15:0] cfgDuration = '0;
  logic        cfgPermanent = 1'b0;
  logic [15:0] cfgValue = '0;
  logic [15:0] cfgAmount = '0;
  logic [7:0]  cfgDelay = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  tt_fault_injector dut (
    .clk(clk), .rstN(rstN), .tick(tick), .cfgArm(cfgArm), .cfgEffect(cfgEffect),
    .cfgTrigTick(cfgTrigTick), .cfgDuration(cfgDuration), .cfgPermanent(cfgPermanent),
    .cfgValue(cfgValue), .cfgAmount(cfgAmount), .cfgDelay(cfgDelay),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  always #5 clk = ~clk;
  always @(negedge clk) tick <= tick + 32'd1;

  // reference model built from the requirements
  bit          mArmed, mActive, mPerm, mValid;
  int          mRem, mDur, mDly;
  logic [31:0] mTrig;
  logic [3:0]  mEff;
  logic [15:0] mVal, mOut, expOut;
  longint      mAmt, mAcc;
  logic [15:0] mHist [16];
  string       expTag;

  function automatic longint satL(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint toS(logic [15:0] x);
    return longint'($signed(x));
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mArmed = 0; mActive = 0; mPerm = 0; mValid = 0;
      mRem = 0; mDur = 0; mDly = 0; mTrig = '0; mEff = '0;
      mVal = '0; mOut = '0; mAmt = 0; mAcc = 0; expOut = '0;
      for (int i = 0; i < 16; i++) mHist[i] = '0;
      expTag = "R1";
    end else begin
      bit start, on;
      longint inL, accN;
      logic [15:0] o;
      string eTag;
      start = mArmed && (tick == mTrig);
      on = start || mActive;
      inL = toS(dataIn);
      accN = 0;
      o = dataIn;
      eTag = "R12";
      if (on) begin
        case (mEff)
          4'd1: begin o = {dataIn[15:1], ~dataIn[0]}; eTag = "R5"; end
          4'd2: begin o = {dataIn[15:1], mVal[0]}; eTag = "R6"; end
          4'd3: begin o = start ? dataIn : mOut; eTag = "R7"; end
          4'd4: begin o = (dataIn == mVal) ? mOut : dataIn; eTag = "R7"; end
          4'd5: begin o = mVal; eTag = "R8"; end
          4'd6: begin o = 16'(satL(inL + mAmt)); eTag = "R8"; end
          4'd7: begin
            accN = start ? mAmt : satL(mAcc + mAmt);
            o = 16'(satL(inL + accN)); eTag = "R9";
          end
          4'd8: begin o = 16'(satL(inL * mAmt)); eTag = "R10"; end
          4'd9: begin o = (mDly == 0) ? dataIn : mHist[mDly-1]; eTag = "R11"; end
          default: begin o = dataIn; eTag = "R12"; end
        endcase
        expTag = {start ? "R2 " : (mPerm ? "R4 " : "R3 "), eTag};
      end else begin
        expTag = "R1/R3";
      end
      mAcc = (on && mEff == 4'd7) ? accN : 0;
      mOut = o;
      expOut = o;
      for (int i = 15; i > 0; i--) mHist[i] = mHist[i-1];
      mHist[0] = dataIn;
      if (start) begin
        mArmed = 0;
        if (mPerm) mActive = 1;
        else begin mActive = (mDur > 1); mRem = mDur - 1; end
      end else if (mActive && !mPerm) begin
        if (mRem == 1) mActive = 0; else mRem = mRem - 1;
      end
      if (cfgArm && !on) begin
        mArmed = 1; mTrig = cfgTrigTick; mDur = int'(cfgDuration);
        mPerm = cfgPermanent; mEff = cfgEffect; mVal = cfgValue;
        mAmt = toS(cfgAmount); mDly = (cfgDelay > 8'd15) ? 15 : int'(cfgDelay);
      end
      mValid = 1;
    end
  end

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dataOut=%h expected=%h at tick %0d", tag, act, exp, tick);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(dataOut, 16'h0000, "R1 reset value");
    rstN = 1'b1;
  endtask

  function automatic logic [15:0] pickData(int mode);
    int r = int'($urandom_range(0, 5));
    if (mode == 1 && r < 2) return cfgValue;
    if (mode == 2 && r == 0) return 16'h7FF0;
    if (mode == 2 && r == 1) return 16'h8010;
    return 16'($urandom);
  endfunction

  // one cycle: compare the sample taken at the last edge, then drive the next one
  task automatic runCycles(int n, int mode, bit noise);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (mValid) check(dataOut, expOut, expTag);
      cfgArm = 1'b0;
      dataIn = pickData(mode);
      if (noise) begin
        cfgEffect = 4'($urandom);
        if ($urandom_range(0, 9) == 0) begin
          cfgArm = 1'b1;
          cfgTrigTick = tick + 32'($urandom_range(1, 4));
          cfgDuration = 16'($urandom_range(0, 4));
          cfgPermanent = 1'b0;
        end
      end
    end
  endtask

  task automatic armFault(input logic [3:0] eff, input int lead, input int dur, input bit perm,
                          input logic [15:0] val, input logic [15:0] amt, input logic [7:0] dly);
    @(negedge clk);
    if (mValid) check(dataOut, expOut, expTag);
    cfgArm = 1'b1; cfgEffect = eff; cfgTrigTick = tick + 32'(lead);
    cfgDuration = 16'(dur); cfgPermanent = perm; cfgValue = val;
    cfgAmount = amt; cfgDelay = dly; dataIn = 16'($urandom);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(dataOut, 16'h0000, "R1 reset value");
    rstN = 1'b1;
    runCycles(20, 0, 1'b0);

    // directed corners
    armFault(4'd9, 5, 0, 1'b1, 16'h0, 16'h0, 8'd200);      // R11 delay saturates to 15
    runCycles(40, 0, 1'b1);
    doReset();
    armFault(4'd7, 3, 0, 1'b1, 16'h0, 16'h3000, 8'd0);     // R9 drift hits the limit
    runCycles(20, 2, 1'b1);
    doReset();
    armFault(4'd8, 2, 6, 1'b0, 16'h0, 16'h0100, 8'd0);     // R10 gain clamps
    runCycles(12, 2, 1'b0);
    armFault(4'd6, 2, 0, 1'b0, 16'h0, 16'h8000, 8'd0);     // R3 zero duration, R8 offset
    runCycles(8, 2, 1'b0);
    armFault(4'd4, 2, 0, 1'b1, 16'h1234, 16'h0, 8'd0);     // R7 conditional freeze
    runCycles(20, 1, 1'b1);
    doReset();

    // constrained random scenarios
    for (int s = 0; s < 80; s++) begin
      int  mode = int'($urandom_range(0, 2));
      bit  perm = ($urandom_range(0, 4) == 0);
      armFault(4'($urandom_range(0, 12)), int'($urandom_range(1, 6)),
               int'($urandom_range(0, 8)), perm, 16'($urandom),
               (mode == 2) ? 16'($urandom) : 16'($urandom_range(0, 40)),
               8'($urandom_range(0, 20)));
      runCycles(int'($urandom_range(15, 30)), mode, $urandom_range(0, 1) == 1);
      if (perm || s % 10 == 9) doReset();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule